// File: doc/BRIEF.md
# SPI Master Transmit/Receive Data Register Front End

This block sits between a 32-bit register bus and the two data queues of an SPI master. A write to the transmit data register is split into queue items. In multiple-data mode a full-width write carries two items, one in each 16-bit half. In single-data mode, and for any half-width access, a write carries one item. Each read of the receive data register pops one item. The word returned carries the item together with the number of the peripheral chip-select that was active when the item was captured. Because of that tag, the receive side always works one item per access.

Both queues count their capacity in items, never in bytes. The configured data width (8 to 16 bits) only masks the item value. Status outputs give the free transmit space, the receive fill level and two emptiness flags. Two sticky flags report a rejected write and a read from an empty queue. The serial shifter connects on the other side through a show-ahead transmit head with a pop strobe and a receive push port.

Top module: `spi_regif`

## Requirements
- R1: After reset, txFree equals DEPTH, rxFill is 0, txEmpty is 1, rxNotEmpty is 0, both sticky flags are 0 and busRdData is 0.
- R2: With multiMode=0, every transmit write pushes exactly one item, taken from busWrData[15:0]. Bits 31:16 are ignored.
- R3: With multiMode=1 and busWrWide=1 (a 32-bit access), a write pushes two items. The first item taken is bits 15:0 and the second is bits 31:16. They leave at txItem in that order.
- R4: With multiMode=1 and busWrWide=0 (a 16-bit access), a write pushes one item from bits 15:0.
- R5: cfgWidth selects the item width: a value n from 0 to 8 gives n+8 bits, and larger values give 16 bits. Bits above that width are stored and read back as zero. A 32-bit write still pushes at most two items at 8 bits.
- R6: The transmit queue holds DEPTH items whatever the width. txFree drops by the number of items pushed and reaches 0 when the queue is full.
- R7: A write that needs more entries than txFree pushes nothing and sets txOverrun. This also applies to a two-item write when only one entry is free. txOvrClr clears the flag, and a new overrun in the same cycle wins over the clear.
- R8: A read with a non-empty receive queue pops one item. From the cycle after the read, busRdData holds the item in bits 15:0, the chip-select number in bits 19:16, and zeros above.
- R9: A read with an empty receive queue loads busRdData with 0, sets rxUnderrun and leaves rxFill unchanged. rxUdrClr clears the flag.
- R10: rxPush stores {rxPushCs, masked rxPushData} unless the receive queue is full. A push into a full queue is dropped and rxFill stays at DEPTH.
- R11: txPop removes the head item and is ignored when the queue is empty. txEmpty is 1 exactly when txFree equals DEPTH, and rxNotEmpty is 1 exactly when rxFill is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| multiMode | input | 1 | 1 selects multiple-data mode for transmit writes |
| cfgWidth | input | 4 | Item width select (n+8 bits, 16 above 8) |
| busWrEn | input | 1 | Write strobe to the transmit data register |
| busWrWide | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe of the receive data register |
| busRdData | output | 32 | Receive word, valid from the cycle after the read |
| txOvrClr | input | 1 | Clears txOverrun |
| rxUdrClr | input | 1 | Clears rxUnderrun |
| txPop | input | 1 | Shifter takes the transmit head item |
| txItem | output | 16 | Transmit head item (show-ahead) |
| rxPush | input | 1 | Shifter delivers a received item |
| rxPushData | input | 16 | Received item |
| rxPushCs | input | 4 | Chip-select number for the received item |
| txFree | output | $clog2(DEPTH+1) | Free transmit entries |
| rxFill | output | $clog2(DEPTH+1) | Stored receive items |
| txEmpty | output | 1 | Transmit queue empty |
| rxNotEmpty | output | 1 | Receive queue holds data |
| txOverrun | output | 1 | Sticky: a transmit write was rejected |
| rxUnderrun | output | 1 | Sticky: an empty receive queue was read |

## Verification
A pointer or count that goes wrong in either queue shows one cycle after the access that caused it. It appears as a txFree or rxFill value that differs from the item count the access implies, or as the wrong item at txItem or in busRdData. A wrong half-word order on a two-item write shows at txItem as soon as the first item has been popped. A capacity check that lets a two-item write through with one free entry shows in the next cycle: txFree wraps or txOverrun stays low. The stimulus therefore reads each item back right after it is written, and it drives each queue to completely full and completely empty.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  typedef struct packed {
    logic txPushOne;
    logic txPushTwo;
    logic rxPop;
    logic setOvr;
    logic setUdr;
  } ctrl_t;

  // width select n gives n+8 valid bits; anything above 8 means 16
  function automatic logic [15:0] widthMask(input logic [3:0] sel);
    logic [4:0] w;
    w = (sel > 4'd8) ? 5'd16 : {1'b0, sel} + 5'd8;
    return 16'((17'd1 << w) - 17'd1);
  endfunction

endpackage

// File: rtl/spi_regif_fifo.sv
module spi_regif_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    pushCnt,
  input  logic [W-1:0]  dinA,
  input  logic [W-1:0]  dinB,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign doPop = pop && (count != '0);
  assign dout  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushCnt != 2'd0) mem[wrPtr] <= dinA;
    if (pushCnt == 2'd2) mem[nxt(wrPtr)] <= dinB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushCnt == 2'd2)      wrPtr <= nxt(nxt(wrPtr));
      else if (pushCnt == 2'd1) wrPtr <= nxt(wrPtr);
      if (doPop) rdPtr <= nxt(rdPtr);
      count <= count + CW'(pushCnt) - CW'(doPop);
    end
  end

endmodule

// File: rtl/spi_regif_ctrl.sv
module spi_regif_ctrl
  import spi_regif_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          multiMode,
  input  logic          busWrEn,
  input  logic          busWrWide,
  input  logic          busRdEn,
  input  logic [CW-1:0] txFree,
  input  logic [CW-1:0] rxFill,
  output ctrl_t         ctrl
);

  logic twoItems;
  logic fits;

  always_comb begin
    twoItems       = multiMode && busWrWide;
    fits           = twoItems ? (txFree >= CW'(2)) : (txFree != '0);
    ctrl.txPushOne = busWrEn && !twoItems && fits;
    ctrl.txPushTwo = busWrEn && twoItems && fits;
    ctrl.setOvr    = busWrEn && !fits;
    ctrl.rxPop     = busRdEn && (rxFill != '0);
    ctrl.setUdr    = busRdEn && (rxFill == '0);
  end

endmodule

// File: rtl/spi_regif_dp.sv
module spi_regif_dp
  import spi_regif_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_t         ctrl,
  input  logic [3:0]    cfgWidth,
  input  logic [31:0]   busWrData,
  input  logic          txOvrClr,
  input  logic          rxUdrClr,
  input  logic          txPop,
  input  logic          rxPush,
  input  logic [15:0]   rxPushData,
  input  logic [3:0]    rxPushCs,
  output logic [15:0]   txItem,
  output logic [CW-1:0] txFree,
  output logic [CW-1:0] rxFill,
  output logic [31:0]   busRdData,
  output logic          txOverrun,
  output logic          rxUnderrun
);

  logic [15:0]   mask;
  logic [CW-1:0] txCount;
  logic [1:0]    txPushCnt;
  logic [1:0]    rxPushCnt;
  logic [19:0]   rxIn;
  logic [19:0]   rxHead;

  assign mask      = widthMask(cfgWidth);
  assign txPushCnt = {ctrl.txPushTwo, ctrl.txPushOne};
  assign rxPushCnt = {1'b0, rxPush && (rxFill != CW'(DEPTH))};
  assign rxIn      = {rxPushCs, rxPushData & mask};
  assign txFree    = CW'(DEPTH) - txCount;

  spi_regif_fifo #(.W(16), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .pushCnt(txPushCnt),
    .dinA(busWrData[15:0] & mask), .dinB(busWrData[31:16] & mask),
    .pop(txPop), .dout(txItem), .count(txCount)
  );

  spi_regif_fifo #(.W(20), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .pushCnt(rxPushCnt),
    .dinA(rxIn), .dinB(20'd0),
    .pop(ctrl.rxPop), .dout(rxHead), .count(rxFill)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData  <= '0;
      txOverrun  <= 1'b0;
      rxUnderrun <= 1'b0;
    end else begin
      if (ctrl.rxPop)       busRdData <= {12'd0, rxHead};
      else if (ctrl.setUdr) busRdData <= '0;
      if (ctrl.setOvr)      txOverrun <= 1'b1;
      else if (txOvrClr)    txOverrun <= 1'b0;
      if (ctrl.setUdr)      rxUnderrun <= 1'b1;
      else if (rxUdrClr)    rxUnderrun <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          multiMode,
  input  logic [3:0]    cfgWidth,
  input  logic          busWrEn,
  input  logic          busWrWide,
  input  logic [31:0]   busWrData,
  input  logic          busRdEn,
  output logic [31:0]   busRdData,
  input  logic          txOvrClr,
  input  logic          rxUdrClr,
  input  logic          txPop,
  output logic [15:0]   txItem,
  input  logic          rxPush,
  input  logic [15:0]   rxPushData,
  input  logic [3:0]    rxPushCs,
  output logic [CW-1:0] txFree,
  output logic [CW-1:0] rxFill,
  output logic          txEmpty,
  output logic          rxNotEmpty,
  output logic          txOverrun,
  output logic          rxUnderrun
);

  ctrl_t ctrl;

  spi_regif_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .multiMode(multiMode), .busWrEn(busWrEn), .busWrWide(busWrWide),
    .busRdEn(busRdEn), .txFree(txFree), .rxFill(rxFill), .ctrl(ctrl)
  );

  spi_regif_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cfgWidth(cfgWidth),
    .busWrData(busWrData), .txOvrClr(txOvrClr), .rxUdrClr(rxUdrClr),
    .txPop(txPop), .rxPush(rxPush), .rxPushData(rxPushData),
    .rxPushCs(rxPushCs), .txItem(txItem), .txFree(txFree),
    .rxFill(rxFill), .busRdData(busRdData), .txOverrun(txOverrun),
    .rxUnderrun(rxUnderrun)
  );

  assign txEmpty    = (txFree == CW'(DEPTH));
  assign rxNotEmpty = (rxFill != '0);

endmodule

// File: rtl/spi_regif_chk.sv
module spi_regif_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          multiMode,
  input logic          busWrEn,
  input logic          busWrWide,
  input logic          busRdEn,
  input logic          txPop,
  input logic          rxPush,
  input logic [31:0]   busRdData,
  input logic [CW-1:0] txFree,
  input logic [CW-1:0] rxFill,
  input logic          txOverrun,
  input logic          rxUnderrun
);

  assert_free_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    txFree <= CW'(DEPTH));

  assert_two_push_R3: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && multiMode && busWrWide && !txPop && (txFree >= CW'(2))
    |=> txFree == $past(txFree) - CW'(2));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && multiMode && busWrWide && !txPop && (txFree < CW'(2))
    |=> txOverrun && (txFree == $past(txFree)));

  assert_single_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && !rxPush && (rxFill != '0) |=> rxFill == $past(rxFill) - CW'(1));

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && (rxFill == '0) |=> rxUnderrun && (busRdData == '0));

  assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxPush && !busRdEn && (rxFill == CW'(DEPTH)) |=> rxFill == CW'(DEPTH));

endmodule

bind spi_regif spi_regif_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .multiMode(multiMode), .busWrEn(busWrEn),
  .busWrWide(busWrWide), .busRdEn(busRdEn), .txPop(txPop), .rxPush(rxPush),
  .busRdData(busRdData), .txFree(txFree), .rxFill(rxFill),
  .txOverrun(txOverrun), .rxUnderrun(rxUnderrun)
);

// File: tb/spi_regif_tb.sv
`timescale 1ns/1ps
module spi_regif_tb;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic multiMode = 1'b0, busWrEn = 1'b0, busWrWide = 1'b0, busRdEn = 1'b0;
  logic [3:0] cfgWidth = 4'd8, rxPushCs = 4'd0;
  logic [31:0] busWrData = '0, busRdData;
  logic txOvrClr = 1'b0, rxUdrClr = 1'b0, txPop = 1'b0, rxPush = 1'b0;
  logic [15:0] txItem, rxPushData = '0;
  logic [CW-1:0] txFree, rxFill;
  logic txEmpty, rxNotEmpty, txOverrun, rxUnderrun;

  int nChecks = 0, nErr = 0;

  always #2.5 clk = ~clk;

  spi_regif #(.DEPTH(DEPTH)) u_dut (.*);

  // {multi, wide, wsel[3:0], data[31:0], n[1:0], item0[15:0], item1[15:0]}
  localparam logic [71:0] VEC [6] = '{
    {1'b0, 1'b1, 4'd8, 32'hBEEF_1234, 2'd1, 16'h1234, 16'h0000},
    {1'b1, 1'b1, 4'd8, 32'hBEEF_1234, 2'd2, 16'h1234, 16'hBEEF},
    {1'b1, 1'b0, 4'd8, 32'hBEEF_1234, 2'd1, 16'h1234, 16'h0000},
    {1'b1, 1'b1, 4'd0, 32'hAABB_CCDD, 2'd2, 16'h00DD, 16'h00BB},
    {1'b0, 1'b0, 4'd4, 32'h0000_F5A5, 2'd1, 16'h05A5, 16'h0000},
    {1'b1, 1'b1, 4'd2, 32'hFFFF_FFFF, 2'd2, 16'h03FF, 16'h03FF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic wide, input logic [31:0] d);
    @(negedge clk); busWrEn = 1'b1; busWrWide = wide; busWrData = d;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic popTx();
    @(negedge clk); txPop = 1'b1;
    @(negedge clk); txPop = 1'b0;
  endtask

  task automatic doRead();
    @(negedge clk); busRdEn = 1'b1;
    @(negedge clk); busRdEn = 1'b0;
  endtask

  task automatic pushRx(input logic [15:0] d, input logic [3:0] cs);
    @(negedge clk); rxPush = 1'b1; rxPushData = d; rxPushCs = cs;
    @(negedge clk); rxPush = 1'b0;
  endtask

  task automatic pulseClr(input logic tx);
    @(negedge clk); if (tx) txOvrClr = 1'b1; else rxUdrClr = 1'b1;
    @(negedge clk); txOvrClr = 1'b0; rxUdrClr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txFree", 32'(txFree), DEPTH);
    chk("R1 rxFill", 32'(rxFill), 0);
    chk("R1 txEmpty", 32'(txEmpty), 1);
    chk("R1 rxNotEmpty", 32'(rxNotEmpty), 0);
    chk("R1 flags", {30'd0, txOverrun, rxUnderrun}, 0);
    chk("R1 busRdData", busRdData, 0);

    // table of transmit write vectors (R2 R3 R4 R5)
    for (int i = 0; i < 6; i++) begin
      logic [71:0] v;
      string tag;
      v = VEC[i];
      tag = !v[71] ? "R2" : !v[70] ? "R4" : (v[69:66] < 4'd8) ? "R5" : "R3";
      @(negedge clk); multiMode = v[71]; cfgWidth = v[69:66];
      doWrite(v[70], v[65:34]);
      chk(tag, 32'(txFree), DEPTH - int'(v[33:32]));
      chk(tag, 32'(txItem), 32'(v[31:16]));
      popTx();
      if (v[33:32] == 2'd2) begin
        chk(tag, 32'(txItem), 32'(v[15:0]));
        popTx();
      end
      chk("R11 txEmpty", 32'(txEmpty), 1);
    end

    // R6 fill to capacity at 8-bit width with two-item writes
    @(negedge clk); multiMode = 1'b1; cfgWidth = 4'd0;
    for (int i = 0; i < DEPTH / 2; i++) doWrite(1'b1, {16'(2*i+1), 16'(2*i)});
    chk("R6 txFree", 32'(txFree), 0);
    chk("R6 txEmpty", 32'(txEmpty), 0);
    // R7 overrun when full, single item
    @(negedge clk); multiMode = 1'b0;
    doWrite(1'b1, 32'h0000_0077);
    chk("R7 overrun", 32'(txOverrun), 1);
    chk("R7 txFree", 32'(txFree), 0);
    pulseClr(1'b1);
    chk("R7 clear", 32'(txOverrun), 0);
    popTx();
    chk("R7 txFree one", 32'(txFree), 1);
    @(negedge clk); multiMode = 1'b1;
    doWrite(1'b1, 32'h0055_0066);
    chk("R7 two into one", 32'(txOverrun), 1);
    chk("R7 nothing pushed", 32'(txFree), 1);
    chk("R11 order", 32'(txItem), 1);
    for (int i = 1; i < DEPTH; i++) popTx();
    popTx();
    chk("R11 pop empty", 32'(txFree), DEPTH);
    pulseClr(1'b1);

    // receive side, 16-bit width
    @(negedge clk); cfgWidth = 4'd8;
    pushRx(16'hA5A5, 4'd3);
    pushRx(16'h0102, 4'd9);
    chk("R11 rxFill", 32'(rxFill), 2);
    chk("R11 rxNotEmpty", 32'(rxNotEmpty), 1);
    doRead();
    chk("R8 word", busRdData, 32'h0003_A5A5);
    chk("R8 rxFill", 32'(rxFill), 1);
    doRead();
    chk("R8 word2", busRdData, 32'h0009_0102);
    doRead();
    chk("R9 zero", busRdData, 0);
    chk("R9 flag", 32'(rxUnderrun), 1);
    chk("R9 rxFill", 32'(rxFill), 0);
    pulseClr(1'b0);
    chk("R9 clear", 32'(rxUnderrun), 0);

    // R5 masking on receive at 8 bits
    @(negedge clk); cfgWidth = 4'd0;
    pushRx(16'h01FF, 4'd1);
    doRead();
    chk("R5 rx mask", busRdData, 32'h0001_00FF);

    // R10 full receive queue drops extra push
    for (int i = 0; i <= DEPTH; i++) pushRx(16'(i + 16), 4'd2);
    chk("R10 full", 32'(rxFill), DEPTH);
    for (int i = 0; i < DEPTH; i++) doRead();
    chk("R10 last kept", busRdData, 32'h0002_0000 | 32'(DEPTH - 1 + 16));
    chk("R10 drained", 32'(rxNotEmpty), 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule